// File: doc/BRIEF.md
# Counting Semaphore Cell with Blocking and Non-Blocking Views

This block is one counting-semaphore cell inside a shared memory that several hardware threads use to synchronise with each other. A request arrives in a single cycle. It carries a thread identifier, a view code and a read or write flag. The cell answers one cycle later with registered read data and a stall flag.

A read through either semaphore view hands back the current count and then lowers it by one, never going below zero. A write through either semaphore view raises the count by one, never going above 0xFFFF. The blocking view and the non-blocking view differ only when a read meets a zero count:
- The blocking view stalls the reader and records it in a per-thread waiting bitmap.
- The non-blocking view returns zero and carries on.

A direct (bypass) view reads or loads the raw count without any side effect. When a semaphore write lifts the count off zero, every recorded waiter gets a one-cycle wake pulse, and its bit is cleared so that the thread can retry.

The cell also exposes a status tag with Empty, Full and queue-type bits. For a semaphore cell these bits are fixed: semaphore traffic never alters them.

Top module: `pv_sema_cell`

## Requirements
- R1: A read in view 2'b01 (blocking) or 2'b10 (non-blocking) with a nonzero count returns the count, zero-extended, on `rsp_rdata` in the cycle after the request. The count then drops by one.
- R2: A write in view 2'b01 or 2'b10 raises the count by one and holds it at 0xFFFF once there. The value on `req_wdata` has no effect. The response data for any write is 0.
- R3: A read in view 2'b01 with a zero count answers with `rsp_stall`=1 and data 0. It leaves the count at zero and sets bit `req_tid` of `blocked_map`.
- R4: A read in view 2'b10 with a zero count answers with `rsp_stall`=0 and data 0. It leaves `blocked_map` unchanged.
- R5: After reset, `tag_empty` reads 1, `tag_full` reads 0 and `tag_fifo` reads 0. No access of any view ever changes them.
- R6: A write in view 2'b01 or 2'b10 that finds the count at zero drives `wake_pulse` for exactly one cycle. The pulse equals the `blocked_map` held before that write, and `blocked_map` clears to zero in the same cycle.
- R7: View 2'b00 (bypass) never stalls and never touches `blocked_map`. A bypass read returns the count unchanged. A bypass write loads `req_wdata[15:0]` into the count.
- R8: View 2'b11 is reserved. A request with that view produces no response and changes neither the count nor `blocked_map`.
- R9: After synchronous reset, the count is 0, `blocked_map` and `wake_pulse` are 0, and `rsp_valid` is 0.
- R10: `rsp_valid` is high in exactly the cycle after each request with a non-reserved view, and low otherwise. `rsp_stall` is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_tid | input | TID_W | Requesting thread number |
| req_view | input | 2 | Access view: 00 bypass, 01 blocking, 10 non-blocking, 11 reserved |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data (used by bypass writes only) |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Read result |
| rsp_stall | output | 1 | Requesting thread must wait |
| tag_empty | output | 1 | Tag Empty bit |
| tag_full | output | 1 | Tag Full bit |
| tag_fifo | output | 1 | Tag queue-type bit (0 for this cell) |
| blocked_map | output | NTHR | One bit per waiting thread |
| wake_pulse | output | NTHR | One-cycle wake per released thread |

## Verification
The bound checker watches, on every cycle, the following rules:
- the decrement and saturating increment of the count;
- the stall-and-record rule for blocking reads at zero;
- the silence of non-blocking and bypass reads;
- the fixed tag bits;
- the release of waiters and the clearing of the bitmap;
- the reserved view and the timing of the response valid.

Only the bench's scenarios can show the cases below:
- that a write with arbitrary data still counts as exactly one increment;
- that a bypass load of a value near the ceiling then saturates correctly;
- that several threads parked in turn are all released by one write and then served in order.

Those cases span many requests and the values that flow between them.

// File: rtl/pv_sema_pkg.sv
package pv_sema_pkg;

  // View codes; numeric values are part of the interface.
  typedef enum logic [1:0] {
    VIEW_BYPASS = 2'b00,
    VIEW_BLOCK  = 2'b01,
    VIEW_TRY    = 2'b10,
    VIEW_RSVD   = 2'b11
  } view_e;

  // Decoded operation for one request.
  typedef struct packed {
    logic take;    // semaphore read with nonzero count
    logic give;    // semaphore write
    logic load;    // bypass write
    logic park;    // blocking read at zero
    logic answer;  // produces a response
  } op_t;

endpackage

// File: rtl/pv_count_unit.sv
module pv_count_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             is_zero,
  output logic             at_max
);

  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  assign is_zero = (count_q == '0);
  assign at_max  = (count_q == MAXC);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (give) begin
      if (!at_max) count_q <= count_q + ONE;
    end else if (take) begin
      count_q <= count_q - ONE;
    end
  end

endmodule

// File: rtl/pv_wait_map.sv
module pv_wait_map #(
  parameter int NTHR  = 4,
  parameter int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             park,
  input  logic [TID_W-1:0] park_tid,
  input  logic             release_all,
  output logic [NTHR-1:0]  map_q,
  output logic [NTHR-1:0]  wake_q
);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic hit;
    assign hit = park && (park_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[t]  <= 1'b0;
        wake_q[t] <= 1'b0;
      end else begin
        wake_q[t] <= release_all & map_q[t];
        if (release_all)  map_q[t] <= 1'b0;
        else if (hit)     map_q[t] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pv_tag_reg.sv
module pv_tag_reg #(
  parameter logic RST_EMPTY = 1'b1,
  parameter logic RST_FULL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output logic empty_q,
  output logic full_q,
  output logic fifo_q
);

  // Semaphore traffic never writes these; they only take reset values.
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= RST_EMPTY;
      full_q  <= RST_FULL;
      fifo_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/pv_sema_cell.sv
module pv_sema_cell
  import pv_sema_pkg::*;
#(
  parameter int NTHR   = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [1:0]        req_view,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_stall,
  output logic              tag_empty,
  output logic              tag_full,
  output logic              tag_fifo,
  output logic [NTHR-1:0]   blocked_map,
  output logic [NTHR-1:0]   wake_pulse
);

  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] count_q;
  logic             is_zero;
  logic             at_max;
  logic             sem_view;
  logic             byp_view;
  op_t              op;
  logic             unused_hi;

  assign unused_hi = ^req_wdata[DATA_W-1:CNT_W] ^ at_max;

  assign sem_view = (req_view == VIEW_BLOCK) || (req_view == VIEW_TRY);
  assign byp_view = (req_view == VIEW_BYPASS);

  always_comb begin
    op        = '0;
    op.answer = req_valid && (sem_view || byp_view);
    op.take   = req_valid && sem_view && !req_write && !is_zero;
    op.give   = req_valid && sem_view &&  req_write;
    op.load   = req_valid && byp_view &&  req_write;
    op.park   = req_valid && (req_view == VIEW_BLOCK) && !req_write && is_zero;
  end

  pv_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .take     (op.take),
    .give     (op.give),
    .load     (op.load),
    .load_val (req_wdata[CNT_W-1:0]),
    .count_q  (count_q),
    .is_zero  (is_zero),
    .at_max   (at_max)
  );

  pv_wait_map #(.NTHR(NTHR), .TID_W(TID_W)) u_wait (
    .clk         (clk),
    .rst         (rst),
    .park        (op.park),
    .park_tid    (req_tid),
    .release_all (op.give && is_zero),
    .map_q       (blocked_map),
    .wake_q      (wake_pulse)
  );

  pv_tag_reg u_tag (
    .clk     (clk),
    .rst     (rst),
    .empty_q (tag_empty),
    .full_q  (tag_full),
    .fifo_q  (tag_fifo)
  );

  // Registered response path.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_stall <= 1'b0;
    end else begin
      rsp_valid <= op.answer;
      rsp_stall <= op.park;
      if (op.answer && !req_write) rsp_rdata <= {{PAD_W{1'b0}}, count_q};
      else                         rsp_rdata <= '0;
    end
  end

endmodule

// File: rtl/pv_sema_cell_chk.sv
module pv_sema_cell_chk #(
  parameter int NTHR   = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int TID_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [TID_W-1:0]  req_tid,
  input logic [1:0]        req_view,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_stall,
  input logic              tag_empty,
  input logic              tag_full,
  input logic              tag_fifo,
  input logic [NTHR-1:0]   blocked_map,
  input logic [NTHR-1:0]   wake_pulse,
  input logic [CNT_W-1:0]  count_q
);

  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic sem, rd0;
  assign sem = req_valid && (req_view == 2'b01 || req_view == 2'b10);
  assign rd0 = !req_write && (count_q == '0);

  assert_pv_read_dec_R1: assert property (@(posedge clk) disable iff (rst)
    (sem && !req_write && count_q != '0) |=>
      (rsp_rdata == DATA_W'($past(count_q)) && count_q == $past(count_q) - ONE));

  assert_pv_write_sat_R2: assert property (@(posedge clk) disable iff (rst)
    (sem && req_write) |=>
      (count_q == (($past(count_q) == MAXC) ? MAXC : $past(count_q) + ONE)));

  assert_block_park_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view == 2'b01 && rd0) |=>
      (rsp_stall && blocked_map[$past(req_tid)] && count_q == '0));

  assert_try_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view == 2'b10 && rd0) |=>
      (!rsp_stall && rsp_rdata == '0 && $stable(blocked_map)));

  assert_tag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $stable(tag_empty) && $stable(tag_full) && !tag_fifo);

  assert_wake_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (|wake_pulse) |-> (blocked_map == '0 && $past(count_q) == '0));

  assert_wake_single_R6: assert property (@(posedge clk) disable iff (rst)
    (|wake_pulse) |=> (wake_pulse == '0));

  assert_bypass_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view == 2'b00) |=> (!rsp_stall && $stable(blocked_map)));

  assert_rsvd_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view == 2'b11) |=>
      (!rsp_valid && $stable(count_q) && $stable(blocked_map)));

  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view != 2'b11) |=> rsp_valid);

  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!req_valid) |=> !rsp_valid);

  assert_stall_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_stall |-> rsp_valid);

endmodule

bind pv_sema_cell pv_sema_cell_chk #(
  .NTHR(NTHR), .CNT_W(CNT_W), .DATA_W(DATA_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
  .req_view(req_view), .req_write(req_write), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall), .tag_empty(tag_empty),
  .tag_full(tag_full), .tag_fifo(tag_fifo), .blocked_map(blocked_map),
  .wake_pulse(wake_pulse), .count_q(count_q)
);

// File: tb/sim_pv_sema_cell.sv
`timescale 1ns/1ps
module sim_pv_sema_cell;

  localparam int NTHR = 4;
  localparam int TIDW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [TIDW-1:0] req_tid = '0;
  logic [1:0]      req_view = 2'b00;
  logic            req_write = 1'b0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid, rsp_stall, tag_empty, tag_full, tag_fifo;
  logic [31:0]     rsp_rdata;
  logic [NTHR-1:0] blocked_map, wake_pulse;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // Behavioural reference state
  int              m_cnt = 0;
  logic [NTHR-1:0] m_map = '0;

  always #4 clk = ~clk;

  pv_sema_cell u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
    .req_view(req_view), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
    .tag_empty(tag_empty), .tag_full(tag_full), .tag_fifo(tag_fifo),
    .blocked_map(blocked_map), .wake_pulse(wake_pulse)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge, predict, compare at the next falling edge.
  task automatic step(input bit v, input int tid, input logic [1:0] view,
                      input bit wr, input logic [31:0] wd, input string rq);
    bit              ev, est;
    int              erd;
    logic [NTHR-1:0] ewake;
    req_valid = v; req_tid = TIDW'(tid); req_view = view;
    req_write = wr; req_wdata = wd;
    ev = v && (view != 2'b11); est = 0; erd = 0; ewake = '0;
    if (ev) begin
      if (view == 2'b00) begin
        if (!wr) erd = m_cnt;
        else     m_cnt = int'(wd & 32'hFFFF);
      end else if (!wr) begin
        if (m_cnt > 0) begin erd = m_cnt; m_cnt--; end
        else if (view == 2'b01) begin est = 1; m_map[tid] = 1'b1; end
      end else begin
        if (m_cnt == 0) begin ewake = m_map; m_map = '0; end
        if (m_cnt < 65535) m_cnt++;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == ev, "R10", "rsp_valid", rsp_valid, ev);
    if (ev) check(rsp_rdata == 32'(erd), rq, "rsp_rdata", rsp_rdata, erd);
    check(rsp_stall == est, rq, "rsp_stall", rsp_stall, est);
    check(blocked_map == m_map, rq, "blocked_map", blocked_map, m_map);
    check(wake_pulse == ewake, rq, "wake_pulse", wake_pulse, ewake);
    check({tag_empty, tag_full, tag_fifo} == 3'b100, "R5", "tag",
          {tag_empty, tag_full, tag_fifo}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check(rsp_valid == 1'b0 && wake_pulse == '0, "R9", "rsp/wake", rsp_valid, 0);
    check(blocked_map == '0, "R9", "blocked_map", blocked_map, 0);
    step(1, 0, 2'b00, 0, 32'h0, "R9");          // bypass read of count 0
    step(1, 1, 2'b10, 0, 32'h0, "R4");          // try read at zero
    step(1, 0, 2'b01, 0, 32'h0, "R3");          // park thread 0
    step(1, 2, 2'b01, 0, 32'h0, "R3");          // park thread 2
    step(1, 3, 2'b00, 0, 32'h0, "R7");          // bypass read leaves map
    step(1, 1, 2'b10, 1, 32'hDEAD_BEEF, "R6");  // wake 0 and 2, count 1
    step(0, 0, 2'b00, 0, 32'h0, "R6");          // pulse gone
    step(1, 1, 2'b01, 0, 32'h0, "R1");          // returns 1
    step(1, 1, 2'b01, 1, 32'h1234_5678, "R2");
    step(1, 2, 2'b10, 1, 32'hFFFF_FFFF, "R2");
    step(1, 3, 2'b10, 0, 32'h0, "R1");          // returns 2
    step(1, 3, 2'b01, 0, 32'h0, "R1");          // returns 1
    step(1, 0, 2'b01, 1, 32'h0, "R6");          // from zero, empty map
    step(1, 0, 2'b00, 1, 32'hABCD_FFFE, "R7");  // load 0xFFFE
    step(1, 0, 2'b01, 1, 32'h0, "R2");          // 0xFFFF
    step(1, 0, 2'b10, 1, 32'h0, "R2");          // saturates
    step(1, 0, 2'b00, 0, 32'h0, "R2");          // reads 0xFFFF
    step(1, 2, 2'b11, 1, 32'h0000_0005, "R8");  // reserved write
    step(1, 2, 2'b11, 0, 32'h0, "R8");          // reserved read
    step(1, 1, 2'b00, 0, 32'h0, "R8");          // count still 0xFFFF
    step(1, 1, 2'b00, 1, 32'h0, "R7");          // load zero
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      step($urandom_range(0, 5) != 0, $urandom_range(0, NTHR-1),
           (sel < 4) ? 2'b01 : (sel < 7) ? 2'b10 : (sel < 9) ? 2'b00 : 2'b11,
           $urandom_range(0, 1) == 1,
           (sel == 7) ? 32'($urandom_range(0, 3)) : $urandom(), "R10");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule